// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes a small set of asynchronous external interrupt pins and turns each one into a clean, clock-aligned request for a downstream interrupt controller. Every pin passes through a multi-flop synchronizer. It then passes through a glitch filter that can be switched on or off, which accepts a new level only once that level has held for several consecutive samples. Last comes a detector that reports a falling edge, a rising edge, either edge, or an active level.

Each pin is set up through its own 4-bit field of one configuration word. The word is written through a single-cycle write strobe and can always be read back. Edge modes produce a one-cycle strobe. Level mode holds the request for as long as the filtered pin sits at its active level. In level mode the filter is always used, and the field's filter bit is reused to select the active level. A short warm-up after reset primes the internal history registers, so the block never reports an edge that only reflects the reset state.

Top module: `ext_irq_detect`

## Requirements
- R1: Field n occupies bits [4n+3:4n] of the configuration word: bit 4n+3 is the filter/polarity bit, bits 4n+2:4n+1 the detection mode, bit 4n a spare tag bit. The word takes the value of parameter CFG_RESET in reset, and the written value is visible on cfg_rdata from the edge that samples cfg_wr.
- R2: Mode 0 raises a one-cycle request on a high-to-low change of the conditioned pin.
- R3: Mode 1 raises a one-cycle request on a low-to-high change of the conditioned pin.
- R4: Mode 2 raises a one-cycle request on every change of the conditioned pin, in either direction.
- R5: Mode 3 holds the request high while the filtered pin equals the filter/polarity bit (1 = active high, 0 = active low), with the filter forced on.
- R6: In modes 0 to 2 a filter/polarity bit of 0 enables the filter. A pin change set up before clock edge k then reaches the request output after edge k+5.
- R7: With the filter on, a pin level must be seen on 4 consecutive samples before it is accepted. A pulse lasting 3 cycles produces no request, and a pulse lasting 4 cycles produces one.
- R8: In modes 0 to 2 a filter/polarity bit of 1 bypasses the filter. A pin change set up before edge k then reaches the request output after edge k+1, so a 1-cycle pulse is detected.
- R9: The tag bit of each field is stored but has no effect on detection.
- R10: No request is raised until the synchronizer and history registers hold real pin samples after reset. Pins that are static through reset and its release produce no request.
- R11: Each pin is detected independently: a change on one pin causes no request on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 4*NUM_PINS | Configuration word to store |
| cfg_rdata | output | 4*NUM_PINS | Stored configuration word |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| req_out | output | NUM_PINS | Per-pin request: strobe in edge modes, held in level mode |

## Verification
The embedded assertions check on every cycle that the configuration read-back follows a write, that the output stays quiet before warm-up ends, that the filter holds its value unless the stable-sample count has run out, and that edge strobes match a real change of the conditioned pin and last one cycle. Only the bench's scenarios can show the latency from pin to request in each mode, that a 3-cycle glitch is rejected while a 4-cycle pulse is accepted, and that polarity selection in level mode works. The same holds for the independence of the pins and for the tag bit having no effect. The bench sweeps every mode, filter setting, edge direction and pin, and predicts each output sample arithmetically.

// File: rtl/eid_pkg.sv
// Shared definitions for the external interrupt pin conditioner.
// Assumes a 4-bit field per pin; bit positions inside a field are fixed.
package eid_pkg;
    typedef enum logic [1:0] {
        DET_FALL  = 2'd0,
        DET_RISE  = 2'd1,
        DET_BOTH  = 2'd2,
        DET_LEVEL = 2'd3
    } det_mode_e;

    localparam int FIELD_W  = 4;
    localparam int POS_FILT = 3;   // filter enable (active low) / level polarity
    localparam int POS_MODE = 1;   // two-bit detection mode
    localparam int POS_TAG  = 0;   // stored only
endpackage

// File: rtl/eid_sync.sv
// Multi-flop synchronizer for one asynchronous pin.
// Assumes STAGES >= 2; resets every stage to 0.
module eid_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the pin sample through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/eid_filter.sv
// Glitch filter: the held value follows the input only after DEPTH
// consecutive differing samples. While primed is low the held value tracks
// the input directly so it starts from a real sample. When enable is low
// the input is passed straight through, but the held value keeps tracking.
module eid_filter #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic primed,
    input  logic enable,
    input  logic d,
    output logic q
);
    localparam int CW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] LIM = CW'(DEPTH - 1);

    logic          filt_q;
    logic [CW-1:0] cnt_q;

    // Count consecutive samples that differ from the held value; accept on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!primed) begin
            filt_q <= d;
            cnt_q  <= '0;
        end else if (d == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == LIM) begin
            filt_q <= d;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign q = enable ? filt_q : d;

    // R7
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && cnt_q != LIM) |=> $stable(filt_q));
    // R7
    filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && d != filt_q && cnt_q == LIM) |=> (filt_q == $past(d)));
endmodule

// File: rtl/eid_detect.sv
// Per-pin detector: edge strobes from the current and previous conditioned
// value, or a held level compared with the polarity bit.
// Assumes armed is high only once prev_q holds a real sample.
module eid_detect
    import eid_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      armed,
    input  det_mode_e mode,
    input  logic      pol,
    input  logic      sig,
    output logic      req
);
    logic prev_q;
    logic hit;

    // Keep one cycle of history of the conditioned pin.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // Select the event that matches the configured mode.
    always_comb begin
        unique case (mode)
            DET_FALL:  hit = prev_q & ~sig;
            DET_RISE:  hit = ~prev_q & sig;
            DET_BOTH:  hit = prev_q ^ sig;
            default:   hit = (sig == pol);
        endcase
    end

    assign req = armed & hit;

    // R2
    fall_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_FALL && req) |-> ($past(sig) && !sig));
    // R3
    rise_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_RISE && req) |-> (!$past(sig) && sig));
endmodule

// File: rtl/ext_irq_detect.sv
// External interrupt pin conditioner top level. Holds the configuration word,
// runs a warm-up counter after reset, and builds one synchronizer, filter
// and detector per pin. Assumes cfg_wr is synchronous to clk.
module ext_irq_detect
    import eid_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 4,
    parameter logic [NUM_PINS*FIELD_W-1:0] CFG_RESET = '0,
    localparam int CFG_W = NUM_PINS * FIELD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] req_out
);
    localparam int WARM_AT = SYNC_STAGES + 1;
    localparam int WCW     = $clog2(WARM_AT + 1);
    localparam logic [WCW-1:0] WARM_LIM = WCW'(WARM_AT);

    logic [CFG_W-1:0] cfg_q;
    logic [WCW-1:0]   warm_q;
    logic             primed;
    logic             armed_q;

    // Store the configuration word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= cfg_wdata;
    end

    assign cfg_rdata = cfg_q;

    // Count cycles after reset until the synchronizers hold real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                warm_q <= '0;
        else if (warm_q != WARM_LIM) warm_q <= warm_q + WCW'(1);
    end

    assign primed = (warm_q == WARM_LIM);

    // Arm the detectors one cycle later, once their history is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= primed;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic      sync_s;
        logic      cond_s;
        logic      pol_s;
        logic      filt_en_s;
        det_mode_e mode_s;

        assign pol_s     = cfg_q[i*FIELD_W + POS_FILT];
        assign mode_s    = det_mode_e'(cfg_q[i*FIELD_W + POS_MODE +: 2]);
        assign filt_en_s = (mode_s == DET_LEVEL) | ~pol_s;

        eid_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_in[i]),
            .q     (sync_s)
        );

        eid_filter #(.DEPTH(FILT_DEPTH)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .primed (primed),
            .enable (filt_en_s),
            .d      (sync_s),
            .q      (cond_s)
        );

        eid_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .armed (armed_q),
            .mode  (mode_s),
            .pol   (pol_s),
            .sig   (cond_s),
            .req   (req_out[i])
        );

        // R3
        rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_wr && mode_s == DET_RISE && req_out[i]) |=> !req_out[i]);
    end

    // R1
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));
    // R10
    quiet_warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (req_out == '0));
endmodule

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic [NP-1:0] pin_in = '1;
    logic [NP-1:0] req_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [NP-1:0] got [1:14];

    always #10 clk = ~clk;

    ext_irq_detect #(.NUM_PINS(NP), .CFG_RESET(16'h4444)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pin_in    (pin_in),
        .req_out   (req_out)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic capture(input int n);
        for (int s = 1; s <= n; s++) begin
            @(negedge clk);
            got[s] = req_out;
        end
    endtask

    // Collect one pin's samples 1..n into a vector (bit s-1 = sample s).
    function automatic logic [13:0] lane(input int q, input int n);
        logic [13:0] v = '0;
        for (int s = 1; s <= n; s++) v[s-1] = got[s][q];
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 / R10: reset value, pins held high, default mode is both-edge with filter.
        repeat (3) @(negedge clk);
        check(cfg_rdata == 16'h4444, "R1 reset value", cfg_rdata, 16'h4444);
        check(req_out == '0, "R10 req in reset", 16'(req_out), 16'h0);
        rst_n = 1'b1;
        capture(14);
        check(lane(0,14) == 0 && lane(1,14) == 0 && lane(2,14) == 0 && lane(3,14) == 0,
              "R10 no request after reset", {lane(3,14) != 0, lane(2,14) != 0, lane(1,14) != 0, lane(0,14) != 0}, 16'h0);

        // R1: write and read back the next cycle.
        write_cfg(16'h5A3C);
        check(cfg_rdata == 16'h5A3C, "R1 readback", cfg_rdata, 16'h5A3C);

        // Sweep: pin, mode, filter bit, direction; tag bit = fe ^ dir (R9).
        for (int p = 0; p < NP; p++) begin
            for (int t = 0; t < 4; t++) begin
                for (int fe = 0; fe < 2; fe++) begin
                    for (int dir = 0; dir < 2; dir++) begin
                        logic        base;
                        logic [3:0]  nib;
                        int          lat;
                        bit          hit;
                        string       tag;
                        base = (dir == 0);
                        nib  = {1'(fe), 2'(t), 1'(fe ^ dir)};
                        write_cfg({4{nib}});
                        pin_in = {NP{base}};
                        repeat (14) @(negedge clk);
                        pin_in[p] = ~base;
                        capture(10);
                        lat = (t == 3 || fe == 0) ? 6 : 2;   // R6 / R8 latency
                        hit = (t == 2) || (t == 1 && dir == 1) || (t == 0 && dir == 0);
                        tag = (t == 0) ? "R2" : (t == 1) ? "R3" : (t == 2) ? "R4" : "R5";
                        for (int q = 0; q < NP; q++) begin
                            logic [13:0] e = '0;
                            for (int s = 1; s <= 10; s++) begin
                                if (t == 3) begin
                                    if (q != p || s < lat) e[s-1] = (base == 1'(fe));
                                    else                   e[s-1] = (~base == 1'(fe));
                                end else begin
                                    e[s-1] = (q == p) && hit && (s == lat);
                                end
                            end
                            check(lane(q,10) == e,
                                  $sformatf("%s%s R9 pin%0d mode%0d fe%0d dir%0d lane%0d",
                                            tag, (q == p) ? (fe ? " R8" : " R6") : " R11",
                                            p, t, fe, dir, q),
                                  16'(lane(q,10)), 16'(e));
                        end
                    end
                end
            end
        end

        // R7: rising mode with filter; a 3-cycle pulse is rejected.
        write_cfg(16'h2222);
        pin_in = '0;
        repeat (14) @(negedge clk);
        pin_in[0] = 1'b1;
        for (int s = 1; s <= 14; s++) begin
            @(negedge clk);
            if (s == 3) pin_in[0] = 1'b0;
            got[s] = req_out;
        end
        check(lane(0,14) == 0, "R7 3-cycle glitch rejected", 16'(lane(0,14)), 16'h0);

        // R7: a 4-cycle pulse is accepted once, at sample 6.
        repeat (6) @(negedge clk);
        pin_in[0] = 1'b1;
        for (int s = 1; s <= 14; s++) begin
            @(negedge clk);
            if (s == 4) pin_in[0] = 1'b0;
            got[s] = req_out;
        end
        check(lane(0,14) == 14'h0020, "R7 4-cycle pulse accepted", 16'(lane(0,14)), 16'h0020);

        // R8: bypass, a 1-cycle pulse is seen at sample 2.
        write_cfg(16'hAAAA);
        repeat (14) @(negedge clk);
        pin_in[0] = 1'b1;
        for (int s = 1; s <= 14; s++) begin
            @(negedge clk);
            if (s == 1) pin_in[0] = 1'b0;
            got[s] = req_out;
        end
        check(lane(0,14) == 14'h0002, "R8 1-cycle pulse in bypass", 16'(lane(0,14)), 16'h0002);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule